// File: doc/BRIEF.md
# Audio Sample FIFO Pair with DMA Levels and Clear Handshake

This block sits between a 32-bit bus/DMA port and an audio serializer. It holds one transmit queue, filled by the bus and drained by the serializer, and one receive queue, filled by the serializer and drained by the bus. From the two fill levels it drives status flags, threshold flags, DMA request lines and higher-priority panic lines. It also keeps a small set of sticky interrupt status bits.

The serializer runs at the bit rate. It is represented here by a one-cycle `ser_tick` strobe in the block's clock. Each queue can be cleared from the bus side, but the clear only takes effect on the serializer's schedule. A separate sync bit, toggled by software, is echoed back on that same schedule, so software can tell that earlier clears have landed.

Top module: `sfq_dma_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, both levels become 0 and `irq_stat` becomes 0. `sync_rb` becomes 0, the empty flag is 1, and the full and has-data flags are 0.
- R2: Words written with `bus_wr_en` leave on `ser_tx_data` in the order written. `ser_tx_pop` advances the queue. `tx_level` counts the stored words, up to 64.
- R3: Words pushed with `ser_rx_push` appear on `bus_rd_data` in the order pushed. `bus_rd_en` advances the queue. `rx_level` counts the stored words, up to 64.
- R4: The following events are dropped and leave the data unchanged: a bus write to a full transmit queue, a serializer pop from an empty transmit queue, a serializer push to a full receive queue, and a bus read from an empty receive queue. Each transmit-side event sets `irq_stat[2]` on the next cycle, and each receive-side event sets `irq_stat[3]`.
- R5: `tx_empty` is 1 exactly when `tx_level` is 0. `rx_full` is 1 exactly when `rx_level` is 64. `rx_has_data` is 1 exactly when `rx_level` is not 0.
- R6: `tx_accept` follows `tx_thr_sel`. The codes are: 0 means the queue is empty, 1 means level below 16, 2 means level below 48, and 3 means level below 64.
- R7: `rx_need` follows `rx_thr_sel`. The codes are: 0 means level at least 1, 1 means level at least 16, 2 means level at least 48, and 3 means level equal to 64.
- R8: `tx_dreq` is 1 when `dma_en` is 1 and `tx_level` is at or below `tx_req_lvl`. `rx_dreq` is 1 when `dma_en` is 1 and `rx_level` is at or above `rx_req_lvl`. Both are 0 while `dma_en` is 0.
- R9: `tx_panic` is 1 when `dma_en` is 1 and `tx_level` is at or below `tx_panic_lvl`. `rx_panic` is 1 when `dma_en` is 1 and `rx_level` is at or above `rx_panic_lvl`.
- R10: `irq_stat` bit positions are 0 for tx_accept, 1 for rx_need, 2 for transmit error and 3 for receive error. A bit is set on the cycle after its condition holds and stays set until a 1 is written to the same bit of `irq_clr`. If a set and a clear land on the same cycle, the set wins. `irq` is the OR of `irq_stat & irq_en`.
- R11: A `clr_tx` or `clr_rx` pulse empties its queue at the second `ser_tick` edge after the pulse. A queue write on that same edge is lost. A further clear pulse on that queue before the empty edge is ignored.
- R12: A `sync_tgl` pulse inverts an internal request bit. `sync_rb` takes the new value at the second `ser_tick` edge after the pulse and changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Bus write into the transmit queue |
| bus_wr_data | input | 32 | Bus write word |
| bus_rd_en | input | 1 | Bus read from the receive queue |
| bus_rd_data | output | 32 | Head of the receive queue |
| ser_tick | input | 1 | Serializer clock strobe |
| ser_tx_pop | input | 1 | Serializer takes the transmit head |
| ser_tx_data | output | 32 | Head of the transmit queue |
| ser_rx_push | input | 1 | Serializer delivers a word |
| ser_rx_data | input | 32 | Word delivered by the serializer |
| clr_tx | input | 1 | Clear command for the transmit queue |
| clr_rx | input | 1 | Clear command for the receive queue |
| sync_tgl | input | 1 | Toggle the sync request bit |
| sync_rb | output | 1 | Sync bit as seen after the serializer round trip |
| tx_thr_sel | input | 2 | tx_accept threshold code |
| rx_thr_sel | input | 2 | rx_need threshold code |
| dma_en | input | 1 | Enables the DMA request and panic lines |
| tx_req_lvl | input | 7 | Transmit request level |
| tx_panic_lvl | input | 7 | Transmit panic level |
| rx_req_lvl | input | 7 | Receive request level |
| rx_panic_lvl | input | 7 | Receive panic level |
| tx_dreq | output | 1 | Transmit DMA request |
| tx_panic | output | 1 | Transmit panic request |
| rx_dreq | output | 1 | Receive DMA request |
| rx_panic | output | 1 | Receive panic request |
| irq_en | input | 4 | Interrupt enables, same bit map as irq_stat |
| irq_clr | input | 4 | Write-1-to-clear strobe for irq_stat |
| irq_stat | output | 4 | Sticky interrupt status |
| irq | output | 1 | Combined interrupt |
| tx_level | output | 7 | Transmit fill level |
| rx_level | output | 7 | Receive fill level |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_has_data | output | 1 | Receive queue holds data |
| tx_accept | output | 1 | Transmit threshold flag |
| rx_need | output | 1 | Receive threshold flag |

## Verification
The directed patterns cover the following:
- Filling the transmit queue past 64 and draining it past empty shows that ordering, drop-on-overflow and error capture are separate effects.
- Sweeping the threshold codes while the level ramps through 16, 48 and 64 tells each code's boundary apart from its neighbour's.
- Clear pulses with sparse serializer ticks, including a repeated pulse and a write on the empty edge, separate the two-tick delay from an immediate flush.
- Sync toggles with gaps between ticks show that the readback moves only on the second tick.

A long mixed phase with random pushes, pops, ticks, clears and level settings is then checked against a queue-based model on every cycle.

// File: rtl/sfq_pkg.sv
package sfq_pkg;

    localparam int WORD_W = 32;

    // interrupt status word, bit 3 down to bit 0
    typedef struct packed {
        logic rx_err;
        logic tx_err;
        logic rx_need;
        logic tx_accept;
    } irq_vec_t;

    typedef enum logic [1:0] {
        THR_EDGE     = 2'd0,
        THR_QUARTER  = 2'd1,
        THR_3QUARTER = 2'd2,
        THR_LIMIT    = 2'd3
    } thr_sel_e;

    function automatic logic tx_accept_f(input int lvl, input thr_sel_e sel, input int depth);
        case (sel)
            THR_EDGE:     return lvl == 0;
            THR_QUARTER:  return lvl < depth / 4;
            THR_3QUARTER: return lvl < (3 * depth) / 4;
            default:      return lvl < depth;
        endcase
    endfunction

    function automatic logic rx_need_f(input int lvl, input thr_sel_e sel, input int depth);
        case (sel)
            THR_EDGE:     return lvl >= 1;
            THR_QUARTER:  return lvl >= depth / 4;
            THR_3QUARTER: return lvl >= (3 * depth) / 4;
            default:      return lvl == depth;
        endcase
    endfunction

endpackage

// File: rtl/sfq_store.sv
module sfq_store #(
    parameter int DEPTH = 64,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    input  logic          flush,
    output logic [W-1:0]  dout,
    output logic [LW-1:0] level,
    output logic          push_drop,
    output logic          pop_drop
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] cnt;
    logic          full, empty, do_push, do_pop;

    assign full      = (cnt == LW'(DEPTH));
    assign empty     = (cnt == '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;
    assign push_drop = push && full;
    assign pop_drop  = pop && empty;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            cnt <= cnt + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    assign dout  = mem[rp];
    assign level = cnt;

    // R11
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (level == '0));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (push_drop && !pop && !flush) |=> $stable(level));

endmodule

// File: rtl/sfq_tick_relay.sv
module sfq_tick_relay (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic req,
    output logic echo,
    output logic arrive
);
    logic s1, s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else if (tick) begin
            s1 <= req;
            s2 <= s1;
        end
    end

    assign echo   = s2;
    assign arrive = tick && (s1 != s2);

    // R12
    echo_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(echo));

endmodule

// File: rtl/sfq_dma_fifo.sv
module sfq_dma_fifo
    import sfq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int W     = WORD_W,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr_en,
    input  logic [W-1:0]  bus_wr_data,
    input  logic          bus_rd_en,
    output logic [W-1:0]  bus_rd_data,
    input  logic          ser_tick,
    input  logic          ser_tx_pop,
    output logic [W-1:0]  ser_tx_data,
    input  logic          ser_rx_push,
    input  logic [W-1:0]  ser_rx_data,
    input  logic          clr_tx,
    input  logic          clr_rx,
    input  logic          sync_tgl,
    output logic          sync_rb,
    input  logic [1:0]    tx_thr_sel,
    input  logic [1:0]    rx_thr_sel,
    input  logic          dma_en,
    input  logic [LW-1:0] tx_req_lvl,
    input  logic [LW-1:0] tx_panic_lvl,
    input  logic [LW-1:0] rx_req_lvl,
    input  logic [LW-1:0] rx_panic_lvl,
    output logic          tx_dreq,
    output logic          tx_panic,
    output logic          rx_dreq,
    output logic          rx_panic,
    input  logic [3:0]    irq_en,
    input  logic [3:0]    irq_clr,
    output logic [3:0]    irq_stat,
    output logic          irq,
    output logic [LW-1:0] tx_level,
    output logic [LW-1:0] rx_level,
    output logic          tx_empty,
    output logic          rx_full,
    output logic          rx_has_data,
    output logic          tx_accept,
    output logic          rx_need
);
    localparam int NDIR = 2;  // index 0 transmit, 1 receive

    logic [NDIR-1:0] clr_cmd, clr_req, clr_echo, clr_hit;
    logic tx_push_drop, tx_pop_drop, rx_push_drop, rx_pop_drop;
    logic sync_req, sync_arrive;
    logic [3:0] irq_q;
    irq_vec_t   set_v;

    assign clr_cmd = {clr_rx, clr_tx};

    // one clear round trip per direction
    for (genvar d = 0; d < NDIR; d++) begin : g_clr
        logic req_q;
        always_ff @(posedge clk) begin
            if (rst)
                req_q <= 1'b0;
            else if (clr_cmd[d] && (req_q == clr_echo[d]))
                req_q <= ~req_q;
        end
        assign clr_req[d] = req_q;

        sfq_tick_relay u_relay (
            .clk    (clk),
            .rst    (rst),
            .tick   (ser_tick),
            .req    (clr_req[d]),
            .echo   (clr_echo[d]),
            .arrive (clr_hit[d])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)           sync_req <= 1'b0;
        else if (sync_tgl) sync_req <= ~sync_req;
    end

    sfq_tick_relay u_sync (
        .clk    (clk),
        .rst    (rst),
        .tick   (ser_tick),
        .req    (sync_req),
        .echo   (sync_rb),
        .arrive (sync_arrive)
    );

    sfq_store #(.DEPTH(DEPTH), .W(W)) u_txq (
        .clk       (clk),
        .rst       (rst),
        .push      (bus_wr_en),
        .din       (bus_wr_data),
        .pop       (ser_tx_pop),
        .flush     (clr_hit[0]),
        .dout      (ser_tx_data),
        .level     (tx_level),
        .push_drop (tx_push_drop),
        .pop_drop  (tx_pop_drop)
    );

    sfq_store #(.DEPTH(DEPTH), .W(W)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .push      (ser_rx_push),
        .din       (ser_rx_data),
        .pop       (bus_rd_en),
        .flush     (clr_hit[1]),
        .dout      (bus_rd_data),
        .level     (rx_level),
        .push_drop (rx_push_drop),
        .pop_drop  (rx_pop_drop)
    );

    assign tx_empty    = (tx_level == '0);
    assign rx_full     = (rx_level == LW'(DEPTH));
    assign rx_has_data = (rx_level != '0);
    assign tx_accept   = tx_accept_f(int'(tx_level), thr_sel_e'(tx_thr_sel), DEPTH);
    assign rx_need     = rx_need_f(int'(rx_level), thr_sel_e'(rx_thr_sel), DEPTH);

    assign tx_dreq  = dma_en && (tx_level <= tx_req_lvl);
    assign tx_panic = dma_en && (tx_level <= tx_panic_lvl);
    assign rx_dreq  = dma_en && (rx_level >= rx_req_lvl);
    assign rx_panic = dma_en && (rx_level >= rx_panic_lvl);

    always_comb begin
        set_v.tx_accept = tx_accept;
        set_v.rx_need   = rx_need;
        set_v.tx_err    = tx_push_drop || tx_pop_drop;
        set_v.rx_err    = rx_push_drop || rx_pop_drop;
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= '0;
        else     irq_q <= (irq_q & ~irq_clr) | set_v;
    end

    assign irq_stat = irq_q;
    assign irq      = |(irq_q & irq_en);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_stat[2] && !irq_clr[2]) |=> irq_stat[2]);

    // R9
    panic_within_req_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_panic && (tx_panic_lvl <= tx_req_lvl)) |-> tx_dreq);

    // R6
    empty_accepts_chk: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> tx_accept);

    // R12
    sync_arrive_chk: assert property (@(posedge clk) disable iff (rst)
        sync_arrive |=> !$stable(sync_rb));

endmodule

// File: tb/sfq_dma_fifo_tb.sv
module sfq_dma_fifo_tb_top;
    localparam int DEPTH = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr_en = 0, bus_rd_en = 0, ser_tick = 0, ser_tx_pop = 0, ser_rx_push = 0;
    logic [31:0] bus_wr_data = '0, ser_rx_data = '0;
    logic [31:0] bus_rd_data, ser_tx_data;
    logic clr_tx = 0, clr_rx = 0, sync_tgl = 0, sync_rb;
    logic [1:0] tx_thr_sel = 0, rx_thr_sel = 0;
    logic dma_en = 0;
    logic [6:0] tx_req_lvl = 0, tx_panic_lvl = 0, rx_req_lvl = 0, rx_panic_lvl = 0;
    logic tx_dreq, tx_panic, rx_dreq, rx_panic;
    logic [3:0] irq_en = 0, irq_clr = 0, irq_stat;
    logic irq;
    logic [6:0] tx_level, rx_level;
    logic tx_empty, rx_full, rx_has_data, tx_accept, rx_need;

    always #4 clk = ~clk;

    sfq_dma_fifo dut_i (
        .clk(clk), .rst(rst),
        .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data),
        .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
        .ser_tick(ser_tick), .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
        .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
        .clr_tx(clr_tx), .clr_rx(clr_rx), .sync_tgl(sync_tgl), .sync_rb(sync_rb),
        .tx_thr_sel(tx_thr_sel), .rx_thr_sel(rx_thr_sel), .dma_en(dma_en),
        .tx_req_lvl(tx_req_lvl), .tx_panic_lvl(tx_panic_lvl),
        .rx_req_lvl(rx_req_lvl), .rx_panic_lvl(rx_panic_lvl),
        .tx_dreq(tx_dreq), .tx_panic(tx_panic), .rx_dreq(rx_dreq), .rx_panic(rx_panic),
        .irq_en(irq_en), .irq_clr(irq_clr), .irq_stat(irq_stat), .irq(irq),
        .tx_level(tx_level), .rx_level(rx_level), .tx_empty(tx_empty), .rx_full(rx_full),
        .rx_has_data(rx_has_data), .tx_accept(tx_accept), .rx_need(rx_need)
    );

    int n_cmp = 0, n_bad = 0;

    task automatic chk(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int unsigned mtq[$];
    int unsigned mrq[$];
    bit [3:0] mst;
    bit m_tx_pend, m_rx_pend, m_tx_pre, m_rx_pre, m_txf, m_rxf;
    int m_tx_cnt, m_rx_cnt;
    bit m_sync_tgt, m_sync_rb;
    int m_sync_ticks;
    int m_tl, m_rl;
    bit m_tx_ev, m_rx_ev;
    bit [3:0] m_set;

    function automatic bit exp_tx_acc(int lvl, int sel);
        if (sel == 0) return lvl == 0;
        if (sel == 1) return lvl < 16;
        if (sel == 2) return lvl < 48;
        return lvl < 64;
    endfunction

    function automatic bit exp_rx_need(int lvl, int sel);
        if (sel == 0) return lvl > 0;
        if (sel == 1) return lvl >= 16;
        if (sel == 2) return lvl >= 48;
        return lvl == 64;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mtq.delete(); mrq.delete(); mst = 0;
            m_tx_pend = 0; m_rx_pend = 0; m_tx_cnt = 0; m_rx_cnt = 0;
            m_sync_tgt = 0; m_sync_rb = 0; m_sync_ticks = 2;
        end else begin
            m_tl = mtq.size(); m_rl = mrq.size();
            m_tx_ev = (bus_wr_en && m_tl == DEPTH) || (ser_tx_pop && m_tl == 0);
            m_rx_ev = (ser_rx_push && m_rl == DEPTH) || (bus_rd_en && m_rl == 0);
            m_set = {m_rx_ev, m_tx_ev, exp_rx_need(m_rl, rx_thr_sel), exp_tx_acc(m_tl, tx_thr_sel)};
            m_tx_pre = m_tx_pend; m_rx_pre = m_rx_pend; m_txf = 0; m_rxf = 0;
            if (ser_tick && m_tx_pend) begin
                if (m_tx_cnt == 1) begin m_txf = 1; m_tx_pend = 0; end else m_tx_cnt = 1;
            end
            if (ser_tick && m_rx_pend) begin
                if (m_rx_cnt == 1) begin m_rxf = 1; m_rx_pend = 0; end else m_rx_cnt = 1;
            end
            if (clr_tx && !m_tx_pre) begin m_tx_pend = 1; m_tx_cnt = 0; end
            if (clr_rx && !m_rx_pre) begin m_rx_pend = 1; m_rx_cnt = 0; end
            if (ser_tx_pop && m_tl > 0) void'(mtq.pop_front());
            if (bus_wr_en && m_tl < DEPTH) mtq.push_back(bus_wr_data);
            if (m_txf) mtq.delete();
            if (bus_rd_en && m_rl > 0) void'(mrq.pop_front());
            if (ser_rx_push && m_rl < DEPTH) mrq.push_back(ser_rx_data);
            if (m_rxf) mrq.delete();
            mst = (mst & ~irq_clr) | m_set;
            if (ser_tick && m_sync_ticks < 2) begin
                m_sync_ticks++;
                if (m_sync_ticks == 2) m_sync_rb = m_sync_tgt;
            end
            if (sync_tgl) begin m_sync_tgt = ~m_sync_tgt; m_sync_ticks = 0; end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!rst) begin
            int tl, rl;
            tl = mtq.size(); rl = mrq.size();
            chk("R2/R11 tx_level", tx_level, tl);
            chk("R3/R11 rx_level", rx_level, rl);
            if (tl > 0) chk("R2 ser_tx_data", ser_tx_data, mtq[0]);
            if (rl > 0) chk("R3 bus_rd_data", bus_rd_data, mrq[0]);
            chk("R5 flags", {tx_empty, rx_full, rx_has_data}, {tl == 0, rl == DEPTH, rl != 0});
            chk("R6 tx_accept", tx_accept, exp_tx_acc(tl, tx_thr_sel));
            chk("R7 rx_need", rx_need, exp_rx_need(rl, rx_thr_sel));
            chk("R8 dreq", {tx_dreq, rx_dreq},
                {dma_en && tl <= int'(tx_req_lvl), dma_en && rl >= int'(rx_req_lvl)});
            chk("R9 panic", {tx_panic, rx_panic},
                {dma_en && tl <= int'(tx_panic_lvl), dma_en && rl >= int'(rx_panic_lvl)});
            chk("R4 error bits", irq_stat[3:2], mst[3:2]);
            chk("R10 irq_stat", irq_stat, mst);
            chk("R10 irq", irq, |(mst & irq_en));
            chk("R12 sync_rb", sync_rb, m_sync_rb);
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc();
        @(negedge clk);
        #2;
    endtask

    task automatic idle();
        bus_wr_en = 0; bus_rd_en = 0; ser_tick = 0; ser_tx_pop = 0; ser_rx_push = 0;
        clr_tx = 0; clr_rx = 0; sync_tgl = 0; irq_clr = 0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state, still in reset
        chk("R1 levels", {tx_level, rx_level}, 0);
        chk("R1 irq_stat", irq_stat, 0);
        chk("R1 sync_rb", sync_rb, 0);
        chk("R1 flags", {tx_empty, rx_full, rx_has_data}, 3'b100);
        #2; rst = 0;
        dma_en = 1; tx_panic_lvl = 7'h10; rx_panic_lvl = 7'h30;
        tx_req_lvl = 7'h30; rx_req_lvl = 7'h20; irq_en = 4'hF;
        tx_thr_sel = 1; rx_thr_sel = 1;
        cyc();
        // R2 R4: overfill transmit queue
        for (int i = 0; i < 70; i++) begin
            bus_wr_en = 1; bus_wr_data = 32'hA000_0000 + i;
            tx_thr_sel = 2'(i / 18);
            cyc();
        end
        idle(); irq_clr = 4'hF; cyc(); idle(); cyc();
        // drain past empty with threshold sweep (R6)
        for (int i = 0; i < 68; i++) begin
            ser_tick = 1; ser_tx_pop = 1; tx_thr_sel = 2'(i / 17);
            cyc();
        end
        idle(); irq_clr = 4'hF; cyc(); idle();
        // R3 R7: receive path
        for (int i = 0; i < 67; i++) begin
            ser_rx_push = 1; ser_rx_data = 32'h5500_0000 + i; rx_thr_sel = 2'(i / 17);
            cyc();
        end
        idle();
        for (int i = 0; i < 66; i++) begin
            bus_rd_en = 1; rx_thr_sel = 2'(3 - i / 17);
            cyc();
        end
        idle(); irq_clr = 4'hC; cyc(); idle();
        // R11: clear with sparse ticks, repeated pulse, write on the empty edge
        for (int i = 0; i < 20; i++) begin
            bus_wr_en = 1; bus_wr_data = i; ser_rx_push = 1; ser_rx_data = ~i; cyc();
        end
        idle(); clr_tx = 1; clr_rx = 1; cyc(); idle();
        cyc(); cyc(); clr_tx = 1; cyc(); idle();
        ser_tick = 1; cyc(); idle(); cyc(); cyc();
        ser_tick = 1; bus_wr_en = 1; bus_wr_data = 32'hDEAD; cyc(); idle();
        bus_wr_en = 1; bus_wr_data = 32'hBEEF; cyc(); idle(); cyc();
        // R12: sync round trips
        for (int k = 0; k < 3; k++) begin
            sync_tgl = 1; cyc(); idle(); cyc(); cyc();
            ser_tick = 1; cyc(); idle(); cyc(); cyc();
            ser_tick = 1; cyc(); idle(); cyc();
        end
        // R8: DMA gate off
        dma_en = 0; cyc(); cyc(); dma_en = 1;
        // mixed random phase
        for (int i = 0; i < 4000; i++) begin
            idle();
            bus_wr_en = ($urandom % 3) != 0; bus_wr_data = $urandom;
            ser_tick = ($urandom % 2) != 0;
            ser_tx_pop = ser_tick && (($urandom % 3) == 0);
            ser_rx_push = ser_tick && (($urandom % 2) == 0); ser_rx_data = $urandom;
            bus_rd_en = ($urandom % 3) == 0;
            clr_tx = ($urandom % 97) == 0; clr_rx = ($urandom % 89) == 0;
            sync_tgl = (m_sync_ticks == 2) && (($urandom % 13) == 0);
            irq_clr = (($urandom % 7) == 0) ? 4'($urandom) : 4'h0;
            irq_en = ((i % 50) == 0) ? 4'($urandom) : irq_en;
            if ((i % 200) == 0) begin
                tx_thr_sel = 2'($urandom); rx_thr_sel = 2'($urandom);
                tx_req_lvl = 7'($urandom % 65); tx_panic_lvl = 7'($urandom % 65);
                rx_req_lvl = 7'($urandom % 65); rx_panic_lvl = 7'($urandom % 65);
                dma_en = ($urandom % 4) != 0;
            end
            if ((i / 500) % 2 == 1) bus_rd_en = 0;
            cyc();
        end
        idle(); cyc(); cyc();
        summary();
    end
endmodule